// File: doc/BRIEF.md
# Flash read prefetch buffer

This block sits between a bus read port and a slow serial flash read engine. It holds one contiguous window of flash data. When a read misses, the block starts a flash burst at an aligned address. It then keeps filling the window well past the word that was asked for, so that later sequential reads are answered locally and do not wait for the flash.

There is only one window, and it cannot be split. A miss that arrives while a burst is still running makes the block abort that burst through a handshake with the engine, and then restart at the new address. If software alternates between two distant blocks, each new access therefore interrupts the previous fill before it finishes. An enable input selects between the full lookahead fill and a single-beat fetch per miss. The enable is sampled when a miss starts a fetch.

The bus side is a request/acknowledge read port: the request and address stay stable until a one-cycle acknowledge that carries the data. The flash side issues a start pulse with an address and a byte length, accepts streamed data beats and a done flag, and offers an abort with an acknowledge.

Top module: `flash_prefetch_buf`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_ack`, `fl_start` and `fl_abort` are low and the window is empty, so the first read starts a fetch and does not raise `fl_abort`.
- R2: With `pf_en` high, a miss produces exactly one single-cycle `fl_start`, with `fl_addr` equal to the request address with its low 3 bits cleared and `fl_len` equal to 1024 bytes.
- R3: Every acknowledge returns on `rd_data` the 32-bit flash word stored at byte address `rd_addr`. Addresses are word aligned, and `rd_ack` is a single-cycle pulse that only follows a pending request.
- R4: A read whose word is already in the window is acknowledged on the first clock edge after the request is seen, and no fetch is started.
- R5: A read that falls inside the window being filled but beyond the words received so far stalls without starting a new fetch. It is acknowledged once that word has arrived.
- R6: A miss while a fill is in progress raises `fl_abort` and holds it until `fl_abort_ack`. The new `fl_start` comes only after the acknowledge.
- R7: Data beats that arrive between an abort request and its acknowledge are discarded. Reads served from the new window return only the new burst's data.
- R8: A sequential read one word past the end of a complete 1024-byte window starts a new fill of the next 1024 bytes without an abort.
- R9: Only one window is held. A read outside it misses even if that data was buffered earlier, and reads that alternate between two distant blocks abort the fill on every switch.
- R10: With `pf_en` low, a miss fetches only the requested word (`fl_addr` equal to the word address, `fl_len` equal to 4), and the next word misses again.
- R11: The mode is taken at the miss. A later change of `pf_en` does not alter the current window until the next miss.
- R12: `fl_done` ends the fill, and a later miss starts a new fetch without raising `fl_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_en | input | 1 | 1 = lookahead fill of a full window, 0 = single-word fetch |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_addr | input | 32 | Byte address of the requested word |
| rd_ack | output | 1 | One-cycle acknowledge, `rd_data` valid |
| rd_data | output | 32 | Returned word |
| fl_start | output | 1 | Burst start pulse to the flash engine |
| fl_addr | output | 32 | Burst start byte address |
| fl_len | output | 11 | Burst length in bytes |
| fl_dv | input | 1 | Data beat valid from the engine |
| fl_data | input | 32 | Data beat |
| fl_done | input | 1 | Burst complete |
| fl_abort | output | 1 | Abort request to the engine |
| fl_abort_ack | input | 1 | Abort completed by the engine |

## Verification
A wrong base, fill count or state shows up at the ports within one request. A bad fill count returns the wrong word, or turns a hit into a long stall. A bad base or range test adds or drops a start pulse, or changes `fl_addr` or `fl_len`, on the very next miss. A bad abort sequence shows as a start that does not wait for the acknowledge, or as stale beats from the aborted burst showing through on the first read from the new window. A wrong mode choice is visible at the next `fl_start` through its length.

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf #(
  parameter int  AW        = 32,
  parameter int  DW        = 32,
  parameter int  BUF_BYTES = 1024,
  parameter int  ALIGN     = 8,
  localparam int LW        = $clog2(BUF_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_en,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic          fl_start,
  output logic [AW-1:0] fl_addr,
  output logic [LW-1:0] fl_len,
  input  logic          fl_dv,
  input  logic [DW-1:0] fl_data,
  input  logic          fl_done,
  output logic          fl_abort,
  input  logic          fl_abort_ack
);
  localparam int BB    = DW / 8;
  localparam int WORDS = BUF_BYTES / BB;
  localparam int IW    = $clog2(WORDS);
  localparam int BSH   = $clog2(BB);
  localparam int ASH   = $clog2(ALIGN);

  typedef enum logic [1:0] {S_IDLE, S_START, S_FILL, S_ABORT} state_t;

  state_t        st;
  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] base;
  logic [IW:0]   tgt;
  logic [IW:0]   fill;
  logic          have;

  logic [AW-1:0] off;
  logic [AW-1:0] span;
  logic [AW-1:0] miss_base;
  logic [IW-1:0] idx;
  logic          serving, in_rng, hit, miss, wr_en;

  assign off       = rd_addr - base;
  assign span      = AW'(tgt) << BSH;
  assign idx       = off[BSH +: IW];
  assign in_rng    = have && (off < span);
  assign serving   = rd_req && !rd_ack && (st == S_IDLE || st == S_FILL);
  assign hit       = serving && in_rng && ({1'b0, idx} < fill);
  assign miss      = serving && !in_rng;
  assign wr_en     = (st == S_FILL) && !miss && fl_dv && (fill < tgt);
  assign miss_base = pf_en ? {rd_addr[AW-1:ASH], {ASH{1'b0}}}
                           : {rd_addr[AW-1:BSH], {BSH{1'b0}}};

  assign fl_start  = (st == S_START);
  assign fl_abort  = (st == S_ABORT);
  assign fl_addr   = base;
  assign fl_len    = LW'(span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base    <= '0;
      tgt     <= '0;
      fill    <= '0;
      have    <= 1'b0;
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= hit;
      if (hit) rd_data <= mem[idx];
      if (miss) begin
        base <= miss_base;
        tgt  <= pf_en ? (IW+1)'(WORDS) : (IW+1)'(1);
        fill <= '0;
        have <= 1'b1;
      end else if (wr_en) begin
        fill <= fill + (IW+1)'(1);
      end
      case (st)
        S_IDLE:  if (miss) st <= S_START;
        S_START: st <= S_FILL;
        S_FILL:  if (miss) st <= S_ABORT;
                 else if (fl_done) st <= S_IDLE;
        S_ABORT: if (fl_abort_ack) st <= S_START;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[fill[IW-1:0]] <= fl_data;
  end
endmodule

// File: rtl/flash_prefetch_buf_chk.sv
module flash_prefetch_buf_chk #(
  parameter int DW        = 32,
  parameter int BUF_BYTES = 1024,
  parameter int ALIGN     = 8,
  parameter int LW        = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_req,
  input logic                     rd_ack,
  input logic                     fl_start,
  input logic [$clog2(ALIGN)-1:0] fl_addr_lo,
  input logic [LW-1:0]            fl_len,
  input logic                     fl_abort,
  input logic                     fl_abort_ack
);
  // R6
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_abort && !fl_abort_ack |=> fl_abort);

  // R6
  start_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> (!$past(fl_abort) || $past(fl_abort_ack)));

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start);

  // R2
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start && (fl_len == LW'(BUF_BYTES)) |-> (fl_addr_lo == '0));

  // R10
  start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> (fl_len == LW'(BUF_BYTES) || fl_len == LW'(DW/8)));

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  // R3
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(rd_req));

  // R5
  no_ack_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> !rd_ack);
endmodule

bind flash_prefetch_buf flash_prefetch_buf_chk #(
  .DW(DW), .BUF_BYTES(BUF_BYTES), .ALIGN(ALIGN), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
  .fl_start(fl_start), .fl_addr_lo(fl_addr[$clog2(ALIGN)-1:0]),
  .fl_len(fl_len), .fl_abort(fl_abort), .fl_abort_ack(fl_abort_ack)
);

// File: tb/flash_prefetch_buf_bench.sv
`timescale 1ns/1ps
module flash_prefetch_buf_bench;
  logic        clk, rst_n, pf_en, rd_req, rd_ack;
  logic [31:0] rd_addr, rd_data, fl_addr, fl_data;
  logic [10:0] fl_len;
  logic        fl_start, fl_dv, fl_done, fl_abort, fl_abort_ack;

  flash_prefetch_buf u_flash_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .fl_start(fl_start), .fl_addr(fl_addr),
    .fl_len(fl_len), .fl_dv(fl_dv), .fl_data(fl_data), .fl_done(fl_done),
    .fl_abort(fl_abort), .fl_abort_ack(fl_abort_ack));

  int n_tests = 0, n_fail = 0;
  int n_start = 0, n_abort = 0;
  logic [31:0] last_addr;
  logic [10:0] last_len;

  initial begin clk = 0; forever #4 clk = ~clk; end

  function automatic logic [31:0] fword(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h9E37_79B9;
  endfunction

  function automatic string rtag(input int n);
    case (n)
      1: return "R1";   2: return "R2";   4: return "R4";   5: return "R5";
      6: return "R6";   7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; 11: return "R11"; 12: return "R12"; default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash engine model: 3-cycle latency, one beat per cycle, abort acknowledged after 2 more beats
  initial begin
    logic [31:0] cur;
    int rem, lat, acnt;
    bit busy, aborting;
    fl_dv = 0; fl_done = 0; fl_abort_ack = 0; fl_data = 0;
    busy = 0; aborting = 0; cur = 0; rem = 0; lat = 0; acnt = 0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        fl_dv <= 0; fl_done <= 0; fl_abort_ack <= 0; busy = 0; aborting = 0;
      end else begin
        fl_dv <= 0; fl_done <= 0;
        if (fl_abort_ack) fl_abort_ack <= 0;
        else if (fl_abort && !aborting) begin aborting = 1; acnt = 2; n_abort++; end
        else if (aborting) begin
          if (acnt == 0) begin fl_abort_ack <= 1; aborting = 0; busy = 0; end
          else acnt--;
        end
        if (fl_start) begin
          cur = fl_addr; rem = int'(fl_len) / 4; lat = 3; busy = 1;
          n_start++; last_addr = fl_addr; last_len = fl_len;
        end else if (busy) begin
          if (lat > 0) lat--;
          else if (rem > 0) begin
            fl_dv <= 1; fl_data <= fword(cur); cur += 4; rem--;
            if (rem == 0) begin fl_done <= 1; busy = 0; end
          end
        end
      end
    end
  end

  task automatic do_read(input logic [31:0] a, input logic pf, output logic [31:0] d, output int lat);
    @(negedge clk);
    pf_en = pf; rd_addr = a; rd_req = 1; lat = 0;
    do begin @(negedge clk); lat++; end while (!rd_ack && lat < 5000);
    d = rd_data; rd_req = 0;
  endtask

  typedef struct packed {
    logic [31:0] addr; logic pf; logic [15:0] gap; logic st; logic ab;
    logic hit; logic stall; logic [31:0] ea; logic [11:0] el; logic [3:0] rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{32'h2404, 1'b1, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h2400, 12'd1024, 4'd2},
    '{32'h2408, 1'b1, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    12'd0,    4'd5},
    '{32'h240C, 1'b1, 16'd300, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    12'd0,    4'd5},
    '{32'h2600, 1'b1, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    12'd0,    4'd4},
    '{32'h27FC, 1'b1, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    12'd0,    4'd4},
    '{32'h2800, 1'b1, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h2800, 12'd1024, 4'd8},
    '{32'h2900, 1'b1, 16'd0,   1'b0, 1'b0, 1'b0, 1'b1, 32'h0,    12'd0,    4'd5},
    '{32'h4010, 1'b1, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 32'h4010, 12'd1024, 4'd6},
    '{32'h2804, 1'b1, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 32'h2800, 12'd1024, 4'd9},
    '{32'h4014, 1'b1, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 32'h4010, 12'd1024, 4'd7},
    '{32'h401C, 1'b1, 16'd300, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    12'd0,    4'd5},
    '{32'h200C, 1'b1, 16'd300, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2008, 12'd1024, 4'd12},
    '{32'h2008, 1'b1, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    12'd0,    4'd4},
    '{32'h3004, 1'b0, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h3004, 12'd4,    4'd10},
    '{32'h3008, 1'b0, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h3008, 12'd4,    4'd10},
    '{32'h3008, 1'b0, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    12'd0,    4'd10},
    '{32'h3008, 1'b1, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    12'd0,    4'd11},
    '{32'h300C, 1'b1, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h3008, 12'd1024, 4'd11},
    '{32'h2400, 1'b1, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 32'h2400, 12'd1024, 4'd9}
  };

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat, s0, a0;
    rst_n = 0; pf_en = 1; rd_req = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rd_ack && !fl_start && !fl_abort, "R1", {rd_ack, fl_start, fl_abort}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_ack && !fl_start && !fl_abort, "R1", {rd_ack, fl_start, fl_abort}, 0);

    for (int i = 0; i < NV; i++) begin
      s0 = n_start; a0 = n_abort;
      do_read(VEC[i].addr, VEC[i].pf, d, lat);
      chk(lat < 5000, rtag(int'(VEC[i].rq)), lat, 0);
      chk(d == fword(VEC[i].addr), (VEC[i].rq == 4'd7) ? "R7" : "R3", d, fword(VEC[i].addr));
      chk((n_start - s0) == int'(VEC[i].st), rtag(int'(VEC[i].rq)), n_start - s0, VEC[i].st);
      chk((n_abort - a0) == int'(VEC[i].ab), rtag(int'(VEC[i].rq)), n_abort - a0, VEC[i].ab);
      if (VEC[i].st) begin
        chk(last_addr == VEC[i].ea, rtag(int'(VEC[i].rq)), last_addr, VEC[i].ea);
        chk(last_len == VEC[i].el[10:0], rtag(int'(VEC[i].rq)), last_len, VEC[i].el);
      end
      if (VEC[i].hit) chk(lat == 1, "R4", lat, 1);
      if (VEC[i].stall) chk(lat > 16, "R5", lat, 17);
      repeat (int'(VEC[i].gap)) @(negedge clk);
    end

    // R1: reset in the middle of a fill empties the window
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(!rd_ack && !fl_start && !fl_abort, "R1", {rd_ack, fl_start, fl_abort}, 0);
    rst_n = 1;
    @(negedge clk);
    s0 = n_start; a0 = n_abort;
    do_read(32'h2404, 1'b1, d, lat);
    chk((n_start - s0) == 1, "R1", n_start - s0, 1);
    chk((n_abort - a0) == 0, "R1", n_abort - a0, 0);
    chk(d == fword(32'h2404), "R3", d, fword(32'h2404));

    summary();
    $finish;
  end
endmodule